// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged L1 Read Lookup

This block is the read lookup path of a level-one data cache that keeps address translation off the critical path. The set to read is chosen with address bits that lie inside the 4 KiB page offset, so they are identical before and after translation. The set read and the translation lookup therefore start in the same cycle. In the following cycle the physical frame number returned by the translation table is compared against the stored tags of both ways of the selected set.

The cache has two ways with 64 sets of 64-byte lines. Replacement uses one least-recently-used bit per set. A small, fully associative translation table is loaded through a plain fill port. Whole lines are written through a refill port. A response reports either a hit with the addressed 32-bit word, a cache miss, or a translation miss.

Requests, responses and refills use valid/ready handshakes. A request is accepted only when the response register is free or is being drained in the same cycle, and no refill is offered in that cycle. A response, once raised, holds every field until `rsp_ready` is seen high. Refills are always accepted. Miss handling toward memory and page-table walks are done by other logic.

Top module: `vil1_lookup`

## Requirements
- R1: After reset `rsp_valid` is 0 and every line is invalid, so a lookup whose translation succeeds reports `rsp_hit`=0 until a refill has written that line.
- R2: The set index is `req_vaddr[11:6]`. The word returned on a hit is word `req_vaddr[5:2]` of the line, where word k is `refill_line[32k+31:32k]`.
- R3: A hit requires three things: a translation hit, a valid way, and a stored tag equal to the translated frame number. Two virtual pages mapped to the same frame therefore hit the same line.
- R4: On a translation miss the response shows `rsp_xlate_miss`=1 and `rsp_hit`=0.
- R5: The response appears in the cycle after the request handshake (`req_valid` and `req_ready` high at a clock edge).
- R6: `req_ready` = (`rsp_valid`=0 or `rsp_ready`=1) and `refill_valid`=0. While `rsp_valid`=1 and `rsp_ready`=0, all response fields stay unchanged.
- R7: `refill_ready` is always 1. A refill writes `refill_line` and `refill_pfn` into the least-recently-used way of set `refill_idx` and marks it valid. That set's LRU bit then points at the other way. The LRU bit of every set starts at way 0. A line already present must not be refilled.
- R8: A hit that completes its response handshake marks the way that hit as most recently used. If a refill to the same set happens in the same cycle, the refill's update wins.
- R9: The translation table has 4 slots, all empty after reset. A fill (`tlb_fill_en`) overwrites the slot `tlb_fill_slot`. When several slots hold the same virtual page number, the lowest-numbered slot supplies the frame.
- R10: When `rsp_hit`=0, `rsp_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request offered |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual byte address of the read |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Line found |
| rsp_xlate_miss | output | 1 | No translation for the page |
| rsp_data | output | 32 | Addressed word on a hit, else 0 |
| tlb_fill_en | input | 1 | Write a translation slot |
| tlb_fill_slot | input | 2 | Slot to write |
| tlb_fill_vpn | input | 20 | Virtual page number |
| tlb_fill_pfn | input | 20 | Physical frame number |
| refill_valid | input | 1 | Line refill offered |
| refill_ready | output | 1 | Refill accepted (always 1) |
| refill_idx | input | 6 | Set to refill |
| refill_pfn | input | 20 | Frame number stored as tag |
| refill_line | input | 512 | Line contents |

## Verification
Most internal faults show up in the response of the very next lookup, one cycle after it is accepted. A corrupted valid bit or tag shows as a hit or miss on the wrong set, and an index taken from translated bits shows as data from the wrong line. A wrong LRU bit stays hidden until the next refill of that set. It then shows when a later lookup of the evicted line hits, or when a lookup of the line that should have survived misses. A translation slot that fails to update, or the wrong priority among slots, shows as the wrong frame's data or a spurious translation miss on the next lookup of that page.

// File: rtl/vil1_pkg.sv
package vil1_pkg;
  parameter int VA_W       = 32;
  parameter int PA_W       = 32;
  parameter int PAGE_OFS_W = 12;
  parameter int LINE_OFS_W = 6;
  parameter int WORD_W     = 32;
  localparam int WAYS   = 2;
  localparam int IDX_W  = PAGE_OFS_W - LINE_OFS_W;
  localparam int SETS   = 1 << IDX_W;
  localparam int VPN_W  = VA_W - PAGE_OFS_W;
  localparam int PFN_W  = PA_W - PAGE_OFS_W;
  localparam int LINE_W = 8 << LINE_OFS_W;
  localparam int WORDS  = LINE_W / WORD_W;
  localparam int WSEL_W = $clog2(WORDS);
  localparam int BSEL_W = LINE_OFS_W - WSEL_W;
endpackage

// File: rtl/vil1_xlate.sv
module vil1_xlate
  import vil1_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_en,
  input  logic [VPN_W-1:0]         lk_vpn,
  input  logic                     fill_en,
  input  logic [$clog2(SLOTS)-1:0] fill_slot,
  input  logic [VPN_W-1:0]         fill_vpn,
  input  logic [PFN_W-1:0]         fill_pfn,
  output logic                     out_hit,
  output logic [PFN_W-1:0]         out_pfn
);
  logic [SLOTS-1:0] ent_v;
  logic [VPN_W-1:0] ent_vpn [SLOTS];
  logic [PFN_W-1:0] ent_pfn [SLOTS];
  logic             hit_c;
  logic [PFN_W-1:0] pfn_c;

  // Lowest slot wins: scan downward so the last assignment is slot 0.
  always_comb begin
    hit_c = 1'b0;
    pfn_c = '0;
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (ent_v[i] && ent_vpn[i] == lk_vpn) begin
        hit_c = 1'b1;
        pfn_c = ent_pfn[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ent_v <= '0;
    else if (fill_en) ent_v[fill_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_vpn[fill_slot] <= fill_vpn;
      ent_pfn[fill_slot] <= fill_pfn;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_hit <= 1'b0;
      out_pfn <= '0;
    end else if (lk_en) begin
      out_hit <= hit_c;
      out_pfn <= pfn_c;
    end
  end
endmodule

// File: rtl/vil1_store.sv
module vil1_store
  import vil1_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_en,
  input  logic [IDX_W-1:0]            rd_idx,
  input  logic [WSEL_W-1:0]           rd_wsel,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [PFN_W-1:0]            wr_tag,
  input  logic [LINE_W-1:0]           wr_line,
  input  logic                        touch_en,
  input  logic [IDX_W-1:0]            touch_idx,
  input  logic                        touch_way,
  output logic [WAYS-1:0]             out_vld,
  output logic [WAYS-1:0][PFN_W-1:0]  out_tag,
  output logic [WAYS-1:0][WORD_W-1:0] out_word
);
  logic [SETS-1:0] lru;
  logic            victim;

  assign victim = lru[wr_idx];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [LINE_W-1:0] mem  [SETS];
    logic [PFN_W-1:0]  tagm [SETS];
    logic [SETS-1:0]   vld;
    logic              sel;

    assign sel = wr_en && (victim == 1'(w));

    always_ff @(posedge clk) begin
      if (sel) begin
        mem[wr_idx]  <= wr_line;
        tagm[wr_idx] <= wr_tag;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld <= '0;
      else if (sel) vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_vld[w]  <= 1'b0;
        out_tag[w]  <= '0;
        out_word[w] <= '0;
      end else if (rd_en) begin
        out_vld[w]  <= vld[rd_idx];
        out_tag[w]  <= tagm[rd_idx];
        out_word[w] <= mem[rd_idx][int'(rd_wsel) * WORD_W +: WORD_W];
      end
    end
  end

  // Refill update is written last so it wins over a same-set touch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lru <= '0;
    else begin
      if (touch_en) lru[touch_idx] <= ~touch_way;
      if (wr_en)    lru[wr_idx]    <= ~victim;
    end
  end

  AST_LRU_FLIP_ON_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> lru[$past(wr_idx)] != $past(lru[wr_idx])); // R7
endmodule

// File: rtl/vil1_match.sv
module vil1_match
  import vil1_pkg::*;
(
  input  logic                        tlb_hit,
  input  logic [PFN_W-1:0]            pfn,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0][PFN_W-1:0]  tag,
  input  logic [WAYS-1:0][WORD_W-1:0] word,
  output logic [WAYS-1:0]             hit_way,
  output logic                        hit,
  output logic [WORD_W-1:0]           data
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_way[w] = tlb_hit && vld[w] && (tag[w] == pfn);
  end

  assign hit = |hit_way;

  always_comb begin
    data = '0;
    for (int w = 0; w < WAYS; w++)
      if (hit_way[w]) data = word[w];
  end
endmodule

// File: rtl/vil1_lookup.sv
module vil1_lookup
  import vil1_pkg::*;
#(
  parameter int TLB_SLOTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic [VA_W-1:0]              req_vaddr,
  output logic                         rsp_valid,
  input  logic                         rsp_ready,
  output logic                         rsp_hit,
  output logic                         rsp_xlate_miss,
  output logic [WORD_W-1:0]            rsp_data,
  input  logic                         tlb_fill_en,
  input  logic [$clog2(TLB_SLOTS)-1:0] tlb_fill_slot,
  input  logic [VPN_W-1:0]             tlb_fill_vpn,
  input  logic [PFN_W-1:0]             tlb_fill_pfn,
  input  logic                         refill_valid,
  output logic                         refill_ready,
  input  logic [IDX_W-1:0]             refill_idx,
  input  logic [PFN_W-1:0]             refill_pfn,
  input  logic [LINE_W-1:0]            refill_line
);
  logic                        req_fire;
  logic                        rsp_fire;
  logic [IDX_W-1:0]            s_idx;
  logic                        x_hit;
  logic [PFN_W-1:0]            x_pfn;
  logic [WAYS-1:0]             c_vld;
  logic [WAYS-1:0][PFN_W-1:0]  c_tag;
  logic [WAYS-1:0][WORD_W-1:0] c_word;
  logic [WAYS-1:0]             hit_way;

  assign refill_ready = 1'b1;
  assign req_ready    = (!rsp_valid || rsp_ready) && !refill_valid;
  assign req_fire     = req_valid && req_ready;
  assign rsp_fire     = rsp_valid && rsp_ready;

  // Set read and translation start together from the same request cycle.
  vil1_xlate #(.SLOTS(TLB_SLOTS)) u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_en     (req_fire),
    .lk_vpn    (req_vaddr[VA_W-1:PAGE_OFS_W]),
    .fill_en   (tlb_fill_en),
    .fill_slot (tlb_fill_slot),
    .fill_vpn  (tlb_fill_vpn),
    .fill_pfn  (tlb_fill_pfn),
    .out_hit   (x_hit),
    .out_pfn   (x_pfn)
  );

  vil1_store u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (req_fire),
    .rd_idx    (req_vaddr[PAGE_OFS_W-1:LINE_OFS_W]),
    .rd_wsel   (req_vaddr[LINE_OFS_W-1:BSEL_W]),
    .wr_en     (refill_valid),
    .wr_idx    (refill_idx),
    .wr_tag    (refill_pfn),
    .wr_line   (refill_line),
    .touch_en  (rsp_fire && rsp_hit),
    .touch_idx (s_idx),
    .touch_way (hit_way[1]),
    .out_vld   (c_vld),
    .out_tag   (c_tag),
    .out_word  (c_word)
  );

  vil1_match u_match (
    .tlb_hit (x_hit),
    .pfn     (x_pfn),
    .vld     (c_vld),
    .tag     (c_tag),
    .word    (c_word),
    .hit_way (hit_way),
    .hit     (rsp_hit),
    .data    (rsp_data)
  );

  assign rsp_xlate_miss = !x_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      s_idx     <= '0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      s_idx     <= req_vaddr[PAGE_OFS_W-1:LINE_OFS_W];
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  AST_RSP_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> rsp_valid); // R5
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit)
      && $stable(rsp_data) && $stable(rsp_xlate_miss)); // R6
  AST_REFILL_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    refill_valid |-> !req_ready); // R6
  AST_XMISS_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_xlate_miss |-> !rsp_hit); // R4
  AST_ONE_WAY_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_way)); // R3
  AST_MISS_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> rsp_data == '0); // R10
endmodule

// File: tb/test_vil1_lookup.sv
module test_vil1_lookup;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [31:0] req_vaddr = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic rsp_hit, rsp_xlate_miss;
  logic [31:0] rsp_data;
  logic tlb_fill_en = 1'b0;
  logic [1:0] tlb_fill_slot = '0;
  logic [19:0] tlb_fill_vpn = '0, tlb_fill_pfn = '0;
  logic refill_valid = 1'b0;
  logic refill_ready;
  logic [5:0] refill_idx = '0;
  logic [19:0] refill_pfn = '0;
  logic [511:0] refill_line = '0;

  int errors = 0;
  int checks = 0;

  localparam logic [19:0] PA = 20'h00A00, PB = 20'h00B00, PC = 20'h00C00;

  always #10 clk = ~clk;

  vil1_lookup i_vil1_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_hit(rsp_hit), .rsp_xlate_miss(rsp_xlate_miss), .rsp_data(rsp_data),
    .tlb_fill_en(tlb_fill_en), .tlb_fill_slot(tlb_fill_slot),
    .tlb_fill_vpn(tlb_fill_vpn), .tlb_fill_pfn(tlb_fill_pfn),
    .refill_valid(refill_valid), .refill_ready(refill_ready),
    .refill_idx(refill_idx), .refill_pfn(refill_pfn), .refill_line(refill_line)
  );

  function automatic logic [31:0] wval(logic [19:0] t, int s, int k);
    return {t[11:0], 2'b00, 6'(s), 4'(k), 8'hA5};
  endfunction

  function automatic logic [31:0] va(logic [19:0] vpn, int s, int k);
    return {vpn, 6'(s), 4'(k), 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tlb(input int slot, input logic [19:0] vpn, input logic [19:0] pfn);
    @(negedge clk);
    tlb_fill_en = 1'b1; tlb_fill_slot = 2'(slot); tlb_fill_vpn = vpn; tlb_fill_pfn = pfn;
    @(negedge clk);
    tlb_fill_en = 1'b0;
  endtask

  task automatic refill(input int s, input logic [19:0] t);
    @(negedge clk);
    refill_valid = 1'b1; refill_idx = 6'(s); refill_pfn = t;
    for (int k = 0; k < 16; k++) refill_line[32*k +: 32] = wval(t, s, k);
    @(negedge clk);
    refill_valid = 1'b0;
  endtask

  // Response is registered at the accepting edge; sample at the next negedge.
  task automatic look(input logic [31:0] a, output logic v, output logic h,
                      output logic x, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = a;
    @(negedge clk);
    req_valid = 1'b0;
    v = rsp_valid; h = rsp_hit; x = rsp_xlate_miss; d = rsp_data;
  endtask

  task automatic expect_rsp(input string req, input logic [31:0] a, input logic eh,
                            input logic ex, input logic [31:0] ed);
    logic v, h, x;
    logic [31:0] d;
    look(a, v, h, x, d);
    chk(v && h == eh && x == ex && d == ed, req, {29'b0, v, h, x, d}, {29'b0, 1'b1, eh, ex, ed});
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic v, h, x;
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(refill_ready == 1'b1, "R7 refill_ready", 64'(refill_ready), 64'd1);
    chk(req_ready == 1'b1, "R6 req_ready idle", 64'(req_ready), 64'd1);

    tlb(0, 20'h00010, PA);
    tlb(1, 20'h00011, PB);
    tlb(2, 20'h00012, PA);
    tlb(3, 20'h00013, PC);

    expect_rsp("R1 cold miss", va(20'h00010, 5, 0), 1'b0, 1'b0, 32'h0);

    for (int s = 0; s < 64; s++) begin
      refill(s, PA);
      refill(s, PB);
    end

    // Sweep every set and word; last hit per set is way 0 (LRU -> way 1).
    for (int s = 0; s < 64; s++) begin
      for (int k = 0; k < 16; k++) begin
        expect_rsp("R2 R3 way B", va(20'h00011, s, k), 1'b1, 1'b0, wval(PB, s, k));
        expect_rsp("R3 R10 absent frame", va(20'h00013, s, k), 1'b0, 1'b0, 32'h0);
        expect_rsp("R4 xlate miss", va(20'h00055, s, k), 1'b0, 1'b1, 32'h0);
        expect_rsp("R3 alias page", va(20'h00012, s, k), 1'b1, 1'b0, wval(PA, s, k));
        expect_rsp("R2 R3 way A", va(20'h00010, s, k), 1'b1, 1'b0, wval(PA, s, k));
      end
    end

    // LRU: set 7 last touched way 0, so a refill evicts B.
    expect_rsp("R8 touch A", va(20'h00010, 7, 1), 1'b1, 1'b0, wval(PA, 7, 1));
    refill(7, PC);
    expect_rsp("R7 B evicted", va(20'h00011, 7, 1), 1'b0, 1'b0, 32'h0);
    expect_rsp("R7 A kept", va(20'h00010, 7, 2), 1'b1, 1'b0, wval(PA, 7, 2));
    expect_rsp("R7 C filled", va(20'h00013, 7, 3), 1'b1, 1'b0, wval(PC, 7, 3));
    // Set 8: touch B last, so A is evicted.
    expect_rsp("R8 touch B", va(20'h00011, 8, 0), 1'b1, 1'b0, wval(PB, 8, 0));
    refill(8, PC);
    expect_rsp("R8 A evicted", va(20'h00010, 8, 4), 1'b0, 1'b0, 32'h0);
    expect_rsp("R8 B kept", va(20'h00011, 8, 5), 1'b1, 1'b0, wval(PB, 8, 5));
    expect_rsp("R8 C filled", va(20'h00013, 8, 6), 1'b1, 1'b0, wval(PC, 8, 6));

    // Back-pressure.
    @(negedge clk);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = va(20'h00010, 3, 2);
    @(negedge clk);
    chk(rsp_valid && rsp_hit && rsp_data == wval(PA, 3, 2), "R5 response after accept",
        64'(rsp_data), 64'(wval(PA, 3, 2)));
    req_vaddr = va(20'h00011, 4, 9);
    for (int i = 0; i < 3; i++) begin
      chk(req_ready == 1'b0, "R6 stalled ready", 64'(req_ready), 64'd0);
      @(negedge clk);
      chk(rsp_valid && rsp_hit && rsp_data == wval(PA, 3, 2), "R6 held response",
          64'(rsp_data), 64'(wval(PA, 3, 2)));
    end
    rsp_ready = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R6 ready on drain", 64'(req_ready), 64'd1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(rsp_valid && rsp_hit && rsp_data == wval(PB, 4, 9), "R6 next after drain",
        64'(rsp_data), 64'(wval(PB, 4, 9)));
    @(negedge clk);
    refill_valid = 1'b1; refill_idx = 6'd20; refill_pfn = PC;
    for (int k = 0; k < 16; k++) refill_line[32*k +: 32] = wval(PC, 20, k);
    #1;
    chk(req_ready == 1'b0, "R6 refill blocks", 64'(req_ready), 64'd0);
    @(negedge clk);
    refill_valid = 1'b0;
    expect_rsp("R7 set20 C", va(20'h00013, 20, 0), 1'b1, 1'b0, wval(PC, 20, 0));
    expect_rsp("R7 set20 B gone", va(20'h00011, 20, 0), 1'b0, 1'b0, 32'h0);

    // Translation table overwrite and priority.
    tlb(3, 20'h00013, PB);
    expect_rsp("R9 overwrite", va(20'h00013, 9, 7), 1'b1, 1'b0, wval(PB, 9, 7));
    tlb(0, 20'h00011, PA);
    expect_rsp("R9 lowest slot", va(20'h00011, 9, 8), 1'b1, 1'b0, wval(PA, 9, 8));
    expect_rsp("R9 old vpn gone", va(20'h00010, 9, 8), 1'b0, 1'b1, 32'h0);

    // Second reset clears valids and table.
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(rsp_valid == 1'b0, "R1 reset again", 64'(rsp_valid), 64'd0);
    expect_rsp("R9 table empty", va(20'h00012, 5, 0), 1'b0, 1'b1, 32'h0);
    tlb(0, 20'h00010, PA);
    look(va(20'h00010, 5, 0), v, h, x, d);
    chk(v && !h && !x && d == 0, "R1 valids cleared", {61'b0, v, h, x}, 64'd4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule